// File: doc/BRIEF.md
# Boot Chain Splitter for a Prefetching Channel Executor

This block drives the boot of a disk-attached machine through a channel executor that always copies the whole command chain out of memory before it begins. A boot chain often loads new commands and then branches into them. A prefetching executor would branch into the stale copy, so the block breaks the chain at every such point and starts the executor again there.

A pulse on `go` runs the whole sequence. The block first writes a lone read command at address 0 and runs it, which loads the first disk record (a program word, a read command and a branch command) into addresses 0x00 to 0x17. It then builds a small program at a fixed base address. That program seeks to record 2 and then runs the record's read command. The branch command's target is kept as the start of the second-stage program. From that point on, the block scans each chain segment before it starts it. Wherever a read with chaining is followed at once by a branch, the block clears the chain flag of that read, runs the segment, and starts again at the branch once the segment completes. The executor is always asked to prefetch. `done` reports a clean finish. `fault` reports an executor error or a chain that is too long.

Commands are 64-bit words. The opcode is bits 63:56, the data address is bits 55:32, the flags are bits 31:24 with the chain flag at bit 30, and the byte count is bits 15:0. A read command is any opcode whose two low bits are 2'b10. A seek is opcode 0x07. A branch is opcode 0x08, and its target is in the address field.

Top module: `boot_chain_splitter`

## Requirements
- R1: After reset, `done`, `fault`, `busy`, `ex_start` and `mem_req` are all low.
- R2: The first start is at address 0x0. Before it, the word at 0x0 holds opcode 0x02, data address 0, chain flag (bit 30) clear and count 24.
- R3: The second start is at BUILD_ADDR (default 0x40). The program there is made of four words. Word 1 is a chained seek (opcode 0x07, count 6) whose address field points to BUILD_ADDR+24. Word 2 is the word from 0x08 with its chain flag cleared. Word 3 is a copy of the word from 0x10. The word at BUILD_ADDR+24 holds 2, the record number, in its low byte.
- R4: The third start is at the address field (bits 55:32) of the word that was at 0x10 after the first record was loaded.
- R5: When a read command with its chain flag set is followed directly by a branch (opcode 0x08), the read's word in memory has bit 30 cleared before the segment is started. All other bits of that word are kept.
- R6: When the segment that held such a read completes, the next start is at the branch command's address, which is the read's address plus 8.
- R7: The scan follows branch targets and stops at the first non-branch command whose chain flag is clear. A segment with no read-then-branch pair is started unmodified, and `done` rises once it completes.
- R8: A segment scan examines at most MAX_CMDS (default 64) commands. A 64-command chain completes normally. A segment that needs a 65th command raises `fault`, and no further start is issued.
- R9: A completion with `ex_err` high raises `fault`, keeps `done` low and issues no further start.
- R10: `ex_prefetch` is always high, so every start asks the executor to prefetch.
- R11: `ex_start` is a one-cycle pulse, and only one start is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Pulse that begins a boot sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished cleanly (held until the next go) |
| fault | output | 1 | Sequence stopped on an error (held until the next go) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after the request |
| ex_start | output | 1 | Start pulse to the executor |
| ex_addr | output | AW | Address of the first command of the started chain |
| ex_prefetch | output | 1 | Prefetch bit of the start request |
| ex_done | input | 1 | Executor completion pulse |
| ex_err | input | 1 | Error status, valid with ex_done |

## Verification
The assertions assume three things about the surroundings. The executor raises `ex_done` only while a start is outstanding. Memory returns read data in the cycle after the request. `go` is not pulsed while the block is busy. The bench has a memory model with one-cycle reads and a prefetching executor model that snapshots memory when a start arrives. The executor answers only after a start, several cycles later. The bench pulses `go` only once the previous sequence has reached `done` or `fault`.

// File: rtl/boot_chain_splitter.sv
module boot_chain_splitter #(
  parameter int AW = 24,
  parameter logic [AW-1:0] BUILD_ADDR = 'h40,
  parameter int MAX_CMDS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  output logic          ex_start,
  output logic [AW-1:0] ex_addr,
  output logic          ex_prefetch,
  input  logic          ex_done,
  input  logic          ex_err
);
  localparam int CW = $clog2(MAX_CMDS + 1);
  localparam logic [AW-1:0] ARG_ADDR = BUILD_ADDR + AW'(24);
  localparam logic [7:0] OP_SEEK   = 8'h07;
  localparam logic [7:0] OP_BRANCH = 8'h08;
  localparam int CHAIN_BIT = 30;
  localparam logic [63:0] FIRST_CMD = {8'h02, 24'h0, 8'h00, 8'h00, 16'd24};
  localparam logic [63:0] SEEK_CMD  = {OP_SEEK, 24'(ARG_ADDR), 8'h40, 8'h00, 16'd6};
  localparam logic [63:0] SEEK_ARG  = 64'd2;

  typedef enum logic [4:0] {
    S_IDLE, S_WIPL, S_RD1, S_RD2, S_RD3, S_WSEEK, S_WREAD, S_WBR, S_WARG,
    S_START, S_WAIT, S_SREQ, S_SCHK, S_PREQ, S_PCHK, S_PATCH, S_DONE, S_FAULT
  } state_t;

  state_t          state, ret;
  logic [63:0]     rd_w, br_w, cur_w;
  logic [AW-1:0]   ptr, seg, start_at;
  logic [CW-1:0]   cnt;

  wire [7:0] rop     = mem_rdata[63:56];
  wire       rchain  = mem_rdata[CHAIN_BIT];
  wire       r_is_br = rop == OP_BRANCH;
  wire       r_is_rd = rop[1:0] == 2'b10;

  assign busy        = !(state inside {S_IDLE, S_DONE, S_FAULT});
  assign done        = state == S_DONE;
  assign fault       = state == S_FAULT;
  assign ex_start    = state == S_START;
  assign ex_addr     = start_at;
  assign ex_prefetch = 1'b1;

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_WIPL:  begin mem_we = 1'b1; mem_wdata = FIRST_CMD; end
      S_RD1:   mem_addr = AW'(8);
      S_RD2:   mem_addr = AW'(16);
      S_WSEEK: begin mem_we = 1'b1; mem_addr = BUILD_ADDR; mem_wdata = SEEK_CMD; end
      S_WREAD: begin
        mem_we = 1'b1; mem_addr = BUILD_ADDR + AW'(8);
        mem_wdata = rd_w; mem_wdata[CHAIN_BIT] = 1'b0;
      end
      S_WBR:   begin mem_we = 1'b1; mem_addr = BUILD_ADDR + AW'(16); mem_wdata = br_w; end
      S_WARG:  begin mem_we = 1'b1; mem_addr = ARG_ADDR; mem_wdata = SEEK_ARG; end
      S_SREQ:  mem_addr = ptr;
      S_PREQ:  mem_addr = ptr + AW'(8);
      S_PATCH: begin
        mem_we = 1'b1; mem_addr = ptr;
        mem_wdata = cur_w; mem_wdata[CHAIN_BIT] = 1'b0;
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ret      <= S_IDLE;
      rd_w     <= '0;
      br_w     <= '0;
      cur_w    <= '0;
      ptr      <= '0;
      seg      <= '0;
      start_at <= '0;
      cnt      <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_FAULT: if (go) state <= S_WIPL;
        S_WIPL: begin start_at <= '0; ret <= S_RD1; state <= S_START; end
        S_RD1:  state <= S_RD2;
        S_RD2:  begin rd_w <= mem_rdata; state <= S_RD3; end
        S_RD3: begin
          br_w  <= mem_rdata;
          ptr   <= AW'(mem_rdata[55:32]);
          seg   <= AW'(mem_rdata[55:32]);
          state <= S_WSEEK;
        end
        S_WSEEK: state <= S_WREAD;
        S_WREAD: state <= S_WBR;
        S_WBR:   state <= S_WARG;
        S_WARG:  begin start_at <= BUILD_ADDR; ret <= S_SREQ; state <= S_START; end
        S_START: begin cnt <= '0; state <= S_WAIT; end
        S_WAIT: if (ex_done) state <= ex_err ? S_FAULT : ret;
        S_SREQ: state <= S_SCHK;
        S_SCHK: begin
          if (cnt == CW'(MAX_CMDS)) state <= S_FAULT;
          else begin
            cnt <= cnt + 1'b1;
            if (r_is_br) begin
              ptr <= AW'(mem_rdata[55:32]);
              state <= S_SREQ;
            end else if (!rchain) begin
              start_at <= seg; ret <= S_DONE; state <= S_START;
            end else if (r_is_rd) begin
              cur_w <= mem_rdata; state <= S_PREQ;
            end else begin
              ptr <= ptr + AW'(8); state <= S_SREQ;
            end
          end
        end
        S_PREQ: state <= S_PCHK;
        S_PCHK: begin
          if (r_is_br) state <= S_PATCH;
          else begin ptr <= ptr + AW'(8); state <= S_SREQ; end
        end
        S_PATCH: begin
          start_at <= seg;
          seg      <= ptr + AW'(8);
          ptr      <= ptr + AW'(8);
          ret      <= S_SREQ;
          state    <= S_START;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_done_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ex_start |=> !ex_start && busy);
  a_r9_err_to_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && ex_done && ex_err) |=> fault && !ex_start);
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_CMDS));
  a_r5_patch_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PATCH) |=> ex_start && ex_addr == $past(seg));
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !mem_req && !ex_start);
endmodule

// File: tb/boot_chain_splitter_test.sv
module boot_chain_splitter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic busy, done, fault, mem_req, mem_we, ex_start, ex_prefetch;
  logic [23:0] mem_addr, ex_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic ex_done = 1'b0;
  logic ex_err = 1'b0;

  always #4 clk = ~clk;

  boot_chain_splitter uut (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .fault(fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ex_start(ex_start), .ex_addr(ex_addr),
    .ex_prefetch(ex_prefetch), .ex_done(ex_done), .ex_err(ex_err)
  );

  logic [63:0] mem  [512];
  logic [63:0] snap [512];
  logic [63:0] disk [512];
  int rbase [8];
  int checks = 0;
  int errors = 0;
  int err_at = -1;
  int start_idx = 0;
  logic [63:0] first_word = '0;
  int exp_q [$];
  string tag_q [$];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:3]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[11:3]];
    end
  end

  function automatic logic [63:0] mk(input logic [7:0] op, input int a, input bit ch, input int n);
    return {op, a[23:0], ch ? 8'h40 : 8'h00, 8'h00, n[15:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_exec(input int addr);
    int pc, pos;
    logic [63:0] w;
    for (int i = 0; i < 512; i++) snap[i] = mem[i];
    pos = 1;
    pc = addr;
    for (int step = 0; step < 300; step++) begin
      w = snap[pc[11:3]];
      if (w[63:56] == 8'h08) begin
        pc = int'(w[55:32]);
      end else begin
        if (w[63:56] == 8'h07) pos = int'(snap[w[43:35]][7:0]);
        else if (w[57:56] == 2'b10) begin
          for (int k = 0; k < int'(w[15:3]); k++)
            mem[(int'(w[55:32]) >> 3) + k] = disk[rbase[pos] + k];
          pos++;
        end
        if (!w[30]) break;
        pc += 8;
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (ex_start) begin
        if (exp_q.size() == 0) chk("R9/R8 unexpected start", 64'(ex_addr), 64'hFFFF_FFFF);
        else chk(tag_q.pop_front(), 64'(ex_addr), 64'(exp_q.pop_front()));
        chk("R10 prefetch bit", 64'(ex_prefetch), 64'd1);
        if (start_idx == 0) first_word = mem[0];
        run_exec(int'(ex_addr));
        repeat (3) @(negedge clk);
        ex_done = 1'b1;
        ex_err = (start_idx == err_at);
        start_idx++;
        @(negedge clk);
        ex_done = 1'b0;
        ex_err = 1'b0;
      end
    end
  end

  task automatic expect_start(input int a, input string tag);
    exp_q.push_back(a);
    tag_q.push_back(tag);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 512; i++) begin mem[i] = '0; disk[i] = '0; end
    start_idx = 0;
    err_at = -1;
  endtask

  task automatic first_record(input int r2_words);
    rbase[1] = 0; rbase[2] = 8; rbase[3] = 200; rbase[4] = 220;
    disk[0] = 64'h0123_0000_0000_1111;
    disk[1] = mk(8'h02, 'h200, 1'b1, r2_words * 8);
    disk[2] = mk(8'h08, 'h200, 1'b0, 0);
  endtask

  task automatic run_and_wait();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    for (int i = 0; i < 5000 && !(done || fault); i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", 64'(done), 0);
    chk("R1 fault", 64'(fault), 0);
    chk("R1 busy", 64'(busy), 0);
    chk("R1 ex_start", 64'(ex_start), 0);
    chk("R1 mem_req", 64'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 prefetch idle", 64'(ex_prefetch), 1);

    // Scenario A: second stage loads a segment and branches into it
    clear_all();
    first_record(4);
    disk[8]  = mk(8'h07, 'h218, 1'b1, 6);
    disk[9]  = mk(8'h02, 'h300, 1'b1, 24);
    disk[10] = mk(8'h08, 'h300, 1'b0, 0);
    disk[11] = 64'd3;
    disk[200] = mk(8'h07, 'h310, 1'b1, 6);
    disk[201] = mk(8'h02, 'h000, 1'b0, 8);
    disk[202] = 64'd4;
    disk[220] = 64'h00AB_CDEF_0000_2222;
    expect_start('h000, "R2 first start");
    expect_start('h040, "R3 built start");
    expect_start('h200, "R4 stage-2 start");
    expect_start('h210, "R6 restart at branch");
    run_and_wait();
    chk("R2 first command", first_word, mk(8'h02, 0, 1'b0, 24));
    chk("R3 seek word", mem['h40 >> 3], mk(8'h07, 'h58, 1'b1, 6));
    chk("R3 read copy", mem['h48 >> 3], mk(8'h02, 'h200, 1'b0, 32));
    chk("R3 branch copy", mem['h50 >> 3], mk(8'h08, 'h200, 1'b0, 0));
    chk("R3 seek argument", mem['h58 >> 3], 64'd2);
    chk("R5 patched read", mem['h208 >> 3], mk(8'h02, 'h300, 1'b0, 24));
    chk("R6 final word at 0", mem[0], 64'h00AB_CDEF_0000_2222);
    chk("R7 done", 64'(done), 1);
    chk("R7 no fault", 64'(fault), 0);
    chk("R6 all starts seen", 64'(exp_q.size()), 0);

    // Scenario B: second stage has no read-then-branch pair
    clear_all();
    first_record(1);
    disk[8] = mk(8'h02, 'h000, 1'b0, 8);
    expect_start('h000, "R2 first start");
    expect_start('h040, "R3 built start");
    expect_start('h200, "R7 unmodified start");
    run_and_wait();
    chk("R7 chain unmodified", mem['h200 >> 3], mk(8'h02, 'h000, 1'b0, 8));
    chk("R7 done", 64'(done), 1);
    chk("R7 all starts seen", 64'(exp_q.size()), 0);

    // Scenario C: executor error on the stage-2 start
    clear_all();
    first_record(4);
    disk[8]  = mk(8'h07, 'h218, 1'b1, 6);
    disk[9]  = mk(8'h02, 'h300, 1'b1, 24);
    disk[10] = mk(8'h08, 'h300, 1'b0, 0);
    disk[11] = 64'd3;
    err_at = 2;
    expect_start('h000, "R2 first start");
    expect_start('h040, "R3 built start");
    expect_start('h200, "R4 stage-2 start");
    run_and_wait();
    chk("R9 fault", 64'(fault), 1);
    chk("R9 no done", 64'(done), 0);
    chk("R9 no restart", 64'(exp_q.size()), 0);

    // Scenario D: 65 chained commands
    clear_all();
    first_record(65);
    for (int i = 0; i < 65; i++) disk[8 + i] = mk(8'h03, 0, 1'b1, 0);
    expect_start('h000, "R2 first start");
    expect_start('h040, "R3 built start");
    run_and_wait();
    chk("R8 overlong fault", 64'(fault), 1);
    chk("R8 no done", 64'(done), 0);
    chk("R8 no stage-2 start", 64'(exp_q.size()), 0);

    // Scenario E: exactly 64 commands
    clear_all();
    first_record(64);
    for (int i = 0; i < 64; i++) disk[8 + i] = mk(8'h03, 0, i != 63, 0);
    expect_start('h000, "R2 first start");
    expect_start('h040, "R3 built start");
    expect_start('h200, "R8 64-command start");
    run_and_wait();
    chk("R8 limit done", 64'(done), 1);
    chk("R8 limit no fault", 64'(fault), 0);
    chk("R8 all starts seen", 64'(exp_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule